// File: doc/BRIEF.md
# Packed-Decimal Digit Shifter

This unit takes a signed packed-decimal operand of 128 bits and moves its digits left or right by a whole number of digit positions. The operand holds 31 decimal digits, four bits each, and a sign code in the lowest nibble. A second 128-bit operand supplies the shift amount as a signed byte. Before the move, the sign code is removed. After the move, a normalized sign code is written back into the low nibble.

Besides the shifted value, the unit produces a four-bit condition code. The code compares the result with zero and reports digits lost off the top of the value. It also flags an operand that is not well-formed decimal. Both outputs are registered, so the result for a given set of inputs appears one clock edge after those inputs are sampled. Any input may change on every cycle.

Top module: `bcd_digit_shifter`

## Requirements
- R1: The shift amount is the two's-complement byte at bits 71:64 of `amt_op`. No other bit of `amt_op` affects the outputs.
- R2: An amount above +31 acts as +31, and an amount below -31 acts as -31.
- R3: A positive amount k moves all digits k places toward the most significant end, filling with zero digits. A negative amount moves them |k| places toward the least significant end, also filling with zeros. An amount of zero keeps the digits where they are. Outputs update on the clock edge that samples the inputs.
- R4: The incoming sign nibble is zeroed before the move. The result's bits 3:0 always hold the normalized sign code, never a shifted digit.
- R5: Sign codes 0xB and 0xD are negative, and 0xA, 0xC, 0xE and 0xF are positive. A negative value is written back as 0xD. A positive value is written back as 0xC when `plus_f` is 0 and as 0xF when it is 1.
- R6: The value operand is well-formed when every digit nibble (bits 127:4) is 0 to 9 and the sign nibble is 0xA to 0xF. Otherwise `cond` is 4'b0001 and `result` is unspecified.
- R7: For a well-formed value, `cond` is {LT, GT, EQ, OV} (bit 3 down to bit 0). EQ is set when all 31 digits of the result are zero, whatever the sign. When EQ is clear, LT is set for a negative sign and GT for a positive one.
- R8: OV (bit 0) is set for a well-formed value only when a move toward the most significant end pushes a nonzero digit past bit 127. It is never set for a zero or negative amount.
- R9: A synchronous active-high `rst` clears `result` and `cond` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| amt_op | input | 128 | Operand carrying the signed shift amount in bits 71:64 |
| val_op | input | 128 | Signed packed-decimal value to shift |
| plus_f | input | 1 | Selects the positive sign code written back (0: 0xC, 1: 0xF) |
| result | output | 128 | Shifted value with normalized sign, registered |
| cond | output | 4 | {LT, GT, EQ, OV} condition code, registered |

## Verification
The assertions assume the inputs hold known values from the first clock edge on. They also assume that the result's sign and digit checks matter only when the previous cycle's value operand was well-formed. The stimulus drives every input at time zero and holds reset through the first edges. It changes inputs only on falling edges and mixes well-formed values with values that have a bad digit or a bad sign, so the checks guarded by well-formedness are exercised both ways. Amounts run across the whole signed byte, including -128, +127 and the clamp limits.

// File: rtl/dshift_pkg.sv
package dshift_pkg;
  localparam int NIB = 4;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic ov;
  } cond_t;

  localparam logic [NIB-1:0] SIGN_NEG   = 4'hD;
  localparam logic [NIB-1:0] SIGN_POS_C = 4'hC;
  localparam logic [NIB-1:0] SIGN_POS_F = 4'hF;
endpackage

// File: rtl/dshift_check.sv
module dshift_check
  import dshift_pkg::*;
#(
  parameter int DIGITS = 31
) (
  input  logic [(DIGITS+1)*NIB-1:0] val,
  output logic                      ok,
  output logic                      neg
);
  localparam int W = (DIGITS+1)*NIB;

  logic [DIGITS-1:0] dig_ok;
  logic [NIB-1:0]    sgn;

  genvar i;
  generate
    for (i = 1; i <= DIGITS; i++) begin : g_dig
      assign dig_ok[i-1] = (val[i*NIB +: NIB] <= 4'd9);
    end
  endgenerate

  assign sgn = val[NIB-1:0];
  assign ok  = (&dig_ok) && (sgn >= 4'hA);
  assign neg = (sgn == 4'hB) || (sgn == 4'hD);
endmodule

// File: rtl/dshift_barrel.sv
module dshift_barrel
  import dshift_pkg::*;
#(
  parameter int DIGITS = 31
) (
  input  logic [(DIGITS+1)*NIB-1:0]   din,
  input  logic [$clog2(DIGITS+1)-1:0] mag,
  input  logic                        left,
  output logic [(DIGITS+1)*NIB-1:0]   dout,
  output logic                        lost
);
  localparam int W      = (DIGITS+1)*NIB;
  localparam int STAGES = $clog2(DIGITS+1);

  logic [W-1:0]   stg   [0:STAGES];
  logic [STAGES:0] spill;

  assign stg[0]   = din;
  assign spill[0] = 1'b0;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      localparam int SH = NIB * (1 << s);
      logic [W-1:0] moved;
      logic         drop;
      assign moved = left ? (stg[s] << SH) : (stg[s] >> SH);
      assign drop  = left && (|stg[s][W-1 -: SH]);
      assign stg[s+1]   = mag[s] ? moved : stg[s];
      assign spill[s+1] = spill[s] | (mag[s] & drop);
    end
  endgenerate

  assign dout = stg[STAGES];
  assign lost = spill[STAGES];
endmodule

// File: rtl/dshift_cond.sv
module dshift_cond
  import dshift_pkg::*;
#(
  parameter int DIGITS = 31
) (
  input  logic [(DIGITS+1)*NIB-1:0] res,
  input  logic                      ok,
  input  logic                      neg,
  input  logic                      lost,
  output cond_t                     cc
);
  localparam int W = (DIGITS+1)*NIB;

  logic zero;
  assign zero = ~|res[W-1:NIB];

  always_comb begin
    if (!ok) begin
      cc = '{lt: 1'b0, gt: 1'b0, eq: 1'b0, ov: 1'b1};
    end else begin
      cc.lt = ~zero & neg;
      cc.gt = ~zero & ~neg;
      cc.eq = zero;
      cc.ov = lost;
    end
  end
endmodule

// File: rtl/bcd_digit_shifter.sv
module bcd_digit_shifter
  import dshift_pkg::*;
#(
  parameter int DIGITS     = 31,
  parameter int COUNT_BYTE = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [(DIGITS+1)*NIB-1:0] amt_op,
  input  logic [(DIGITS+1)*NIB-1:0] val_op,
  input  logic                      plus_f,
  output logic [(DIGITS+1)*NIB-1:0] result,
  output logic [3:0]                cond
);
  localparam int W      = (DIGITS+1)*NIB;
  localparam int CW     = $clog2(DIGITS+1);
  localparam int CB_LSB = W - 8*(COUNT_BYTE+1);
  localparam logic signed [7:0] LIM = 8'(DIGITS);

  logic signed [7:0] cnt;
  logic [7:0]        mag8;
  logic              go_left;
  logic              ok, neg, lost;
  logic [W-1:0]      stripped, moved, nxt;
  logic [NIB-1:0]    sign_out;
  cond_t             cc_nxt;

  assign cnt     = $signed(amt_op[CB_LSB +: 8]);
  assign go_left = (cnt > 8'sd0);

  always_comb begin
    if (cnt > LIM || cnt < -LIM) mag8 = 8'(DIGITS);
    else if (cnt < 8'sd0)        mag8 = 8'(-cnt);
    else                         mag8 = 8'(cnt);
  end

  dshift_check #(.DIGITS(DIGITS)) u_check (
    .val (val_op),
    .ok  (ok),
    .neg (neg)
  );

  assign stripped = {val_op[W-1:NIB], {NIB{1'b0}}};

  dshift_barrel #(.DIGITS(DIGITS)) u_barrel (
    .din  (stripped),
    .mag  (mag8[CW-1:0]),
    .left (go_left),
    .dout (moved),
    .lost (lost)
  );

  assign sign_out = neg ? SIGN_NEG : (plus_f ? SIGN_POS_F : SIGN_POS_C);
  assign nxt      = {moved[W-1:NIB], sign_out};

  dshift_cond #(.DIGITS(DIGITS)) u_cond (
    .res  (nxt),
    .ok   (ok),
    .neg  (neg),
    .lost (lost),
    .cc   (cc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      cond   <= '0;
    end else begin
      result <= nxt;
      cond   <= cc_nxt;
    end
  end

  // Clamped magnitude never exceeds the digit count
  assert_clamp_R2: assert property (@(posedge clk) disable iff (rst)
    mag8 <= 8'(DIGITS));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (result == '0 && cond == 4'b0000));

  assert_bad_operand_R6: assert property (@(posedge clk) disable iff (rst)
    !ok |=> cond == 4'b0001);

  assert_sign_code_R5: assert property (@(posedge clk) disable iff (rst)
    ok |=> (result[3:0] == 4'hC || result[3:0] == 4'hD || result[3:0] == 4'hF));

  assert_one_compare_R7: assert property (@(posedge clk) disable iff (rst)
    ok |=> $onehot(cond[3:1]));

  assert_eq_zero_R7: assert property (@(posedge clk) disable iff (rst)
    ok |=> (cond[1] == (result[W-1:NIB] == '0)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (ok && $signed(amt_op[CB_LSB +: 8]) <= 8'sd0) |=> !cond[0]);
endmodule

// File: tb/sim_bcd_digit_shifter.sv
module sim_bcd_digit_shifter;
  logic         clk = 1'b0;
  logic         rst;
  logic [127:0] amt_op, val_op;
  logic         plus_f;
  logic [127:0] result;
  logic [3:0]   cond;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bcd_digit_shifter u0 (
    .clk(clk), .rst(rst), .amt_op(amt_op), .val_op(val_op),
    .plus_f(plus_f), .result(result), .cond(cond)
  );

  function automatic logic [127:0] amt(input logic [7:0] c);
    return {56'hA5A5A5A5A5A5A5, c, 64'h5A5A5A5A5A5A5A5A};
  endfunction

  // Behavioural model built from the requirements
  function automatic void model(input logic [127:0] a, input logic [127:0] b,
                                input logic p, output logic [127:0] r,
                                output logic [3:0] c, output bit good);
    int d[32];
    int nd[32];
    int k;
    bit ovf = 0, neg, zero = 1;
    good = 1;
    d[0] = 0;
    for (int i = 1; i < 32; i++) begin
      d[i] = int'(b[4*i +: 4]);
      if (d[i] > 9) good = 0;
    end
    if (b[3:0] < 4'hA) good = 0;
    neg = (b[3:0] == 4'hB) || (b[3:0] == 4'hD);
    k = int'($signed(a[71:64]));
    if (k > 31) k = 31;
    if (k < -31) k = -31;
    for (int i = 0; i < 32; i++) begin
      if (k >= 0) nd[i] = (i - k >= 0) ? d[i-k] : 0;
      else        nd[i] = (i - k <= 31) ? d[i-k] : 0;
    end
    if (k > 0)
      for (int j = 1; j < 32; j++)
        if (j + k > 31 && d[j] != 0) ovf = 1;
    r = '0;
    for (int i = 1; i < 32; i++) begin
      r[4*i +: 4] = 4'(nd[i]);
      if (nd[i] != 0) zero = 0;
    end
    r[3:0] = neg ? 4'hD : (p ? 4'hF : 4'hC);
    if (!good) c = 4'b0001;
    else c = {!zero && neg, !zero && !neg, zero, ovf};
  endfunction

  // Call at a falling edge: drive, wait one cycle, compare
  task automatic run(input logic [127:0] a, input logic [127:0] b,
                     input logic p, input string req);
    logic [127:0] er;
    logic [3:0]   ec;
    bit good;
    amt_op = a; val_op = b; plus_f = p;
    model(a, b, p, er, ec, good);
    @(negedge clk);
    checks++;
    if (cond !== ec) begin
      errors++;
      $display("FAIL %s cond: got %b expected %b (val %h amt byte %h)",
               req, cond, ec, b, a[71:64]);
    end
    if (good) begin
      checks++;
      if (result !== er) begin
        errors++;
        $display("FAIL %s result: got %h expected %h", req, result, er);
      end
    end
  endtask

  localparam logic [127:0] V_FULL = 128'h1234567890123456789012345678901C;
  localparam logic [127:0] V_NEG  = 128'h0000000000000000000000000000042D;

  initial begin
    rst = 1'b1; amt_op = '0; val_op = '0; plus_f = 1'b0;
    @(negedge clk); @(negedge clk);
    checks++;
    if (result !== '0 || cond !== 4'b0000) begin
      errors++;
      $display("FAIL R9 reset: got %h/%b expected 0/0000", result, cond);
    end
    rst = 1'b0;
    run(amt(8'd0),    V_FULL, 1'b0, "R3 zero amount");
    run(amt(8'd1),    V_FULL, 1'b0, "R8 left 1 drops top digit");
    run(amt(8'd3),    V_NEG,  1'b0, "R3 left 3");
    run(amt(8'd29),   V_NEG,  1'b0, "R3 left 29 keeps 42");
    run(amt(8'd30),   V_NEG,  1'b0, "R8 left 30 drops 4");
    run(amt(8'd31),   V_NEG,  1'b0, "R8 left 31 loses all");
    run(amt(8'd40),   V_NEG,  1'b0, "R2 clamp +40");
    run(amt(8'd127),  V_FULL, 1'b1, "R2 clamp +127");
    run(amt(8'hFF),   V_FULL, 1'b0, "R4 right 1 sign not digit");
    run(amt(8'hFB),   V_FULL, 1'b1, "R3 right 5");
    run(amt(8'hE1),   V_FULL, 1'b0, "R3 right 31");
    run(amt(8'h9C),   V_FULL, 1'b0, "R2 clamp -100");
    run(amt(8'h80),   V_NEG,  1'b0, "R8 clamp -128 no ov");
    run({~56'h0, 8'd2, ~64'h0}, V_NEG, 1'b0, "R1 other bytes ignored");
    run(amt(8'd1), 128'h0000000000000000000000000000000B, 1'b0, "R7 neg zero is EQ");
    run(amt(8'd2), 128'h0000000000000000000000000000007A, 1'b0, "R5 A to C");
    run(amt(8'd2), 128'h0000000000000000000000000000007A, 1'b1, "R5 A to F");
    run(amt(8'd0), 128'h0000000000000000000000000000003E, 1'b1, "R5 E to F");
    run(amt(8'd0), 128'h0000000000000000000000000000005F, 1'b0, "R5 F to C");
    run(amt(8'd0), 128'h0000000000000000000000000000009B, 1'b1, "R5 B to D");
    run(amt(8'd1), 128'h000000000000000000000000000A001C, 1'b0, "R6 bad digit");
    run(amt(8'd1), 128'h00000000000000000000000000000015, 1'b0, "R6 bad sign");
    run(amt(8'd0), 128'h00000000000000000000000000000000, 1'b0, "R6 sign zero");
    run(amt(8'd31), 128'hF000000000000000000000000000000C, 1'b0, "R6 bad top digit");
    for (int n = 0; n < 400; n++) begin
      logic [127:0] v;
      for (int i = 1; i < 32; i++) v[4*i +: 4] = 4'($urandom_range(0, (n % 4 == 0) ? 15 : 9));
      v[3:0] = 4'($urandom_range(10, 15));
      if (n % 16 == 0) v[127:68] = '0;
      run(amt(8'($urandom_range(0, 255))), v, 1'($urandom_range(0, 1)), "R3 R7 R8 random");
    end
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (result !== '0 || cond !== 4'b0000) begin
      errors++;
      $display("FAIL R9 mid-run reset: got %h/%b expected 0/0000", result, cond);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule